// File: doc/BRIEF.md
# Graphics DRAM Power-Up Sequencer

This block owns the command pins of a two-bank synchronous graphics DRAM from reset until the memory can accept normal traffic. While reset is applied and for a programmable settling time afterwards, it keeps clock enable high, every data-mask bit high and a no-operation command on the bus. After that it issues a fixed set of initialisation commands. First comes a precharge of all banks. Then come a configurable number of auto-refresh commands and a mode register load, in an order chosen by a configuration input. An optional special mode register load can follow, which enables the colour or mask register loads.

Between commands the sequencer inserts the programmed minimum gaps: tRP after the precharge, tRC after each refresh and tMRD after each mode load. It drives only no-operation commands during these gaps. When the final gap has expired it raises `ready` and releases the data masks. From then on it holds the bus idle, so the controller's normal traffic logic can take over. The settling time is set as microseconds times the clock frequency in MHz. The refresh count must be at least 2, and every gap must be at least one cycle.

Top module: `gram_init_seq`

## Requirements
- R1: During reset and for STAB_CYC = STAB_US*CLK_MHZ cycles after reset is released, the bus shows NOP with `cke`=1, all `dqm` bits 1 and `ready`=0. The precharge appears on the pins in the cycle after the STAB_CYC-th rising edge following release.
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n, dsf} as follows: NOP=01110, precharge=00100, auto-refresh=00010, mode load=00000, special mode load=00001. `ba` is 0 throughout.
- R3: The precharge drives addr[10]=1 (all banks) with all other address bits 0. Refresh and NOP cycles drive the address as 0.
- R4: With `cfg_mrs_first`=0 the order is: precharge, then N_REFRESH refreshes, then the mode load, then the special mode load if `cfg_smrs_en`=1.
- R5: With `cfg_mrs_first`=1 the order is: precharge, then the mode load, then the special mode load if enabled, then N_REFRESH refreshes.
- R6: The mode load drives `cfg_mode_word` on the address with bits 10, 8 and 7 forced to 0. All other bits pass through unchanged.
- R7: The special mode load drives addr[6]=`cfg_load_color` and addr[5]=`cfg_load_mask`, with all other bits 0. If both are requested, addr[6] and addr[5] are both driven 0 and `cfg_err`=1. `cfg_err` is 1 exactly when `cfg_smrs_en`, `cfg_load_color` and `cfg_load_mask` are all 1.
- R8: The next command appears exactly T_RP cycles after a precharge, T_RC cycles after a refresh and T_MRD cycles after a mode or special mode load. The cycles in between are NOP.
- R9: `ready` rises exactly one gap (per R8) after the last command, and `dqm` goes to 0 in the same cycle. After that `ready` stays 1 and the bus stays NOP until reset.
- R10: Asserting `rst_n` low at any point restarts the sequence from the settling wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode_word | input | ADDR_W | Mode word for the mode load |
| cfg_mrs_first | input | 1 | Issue mode load before the refreshes |
| cfg_smrs_en | input | 1 | Issue the special mode load |
| cfg_load_color | input | 1 | Colour-load enable for the special mode load |
| cfg_load_mask | input | 1 | Mask-load enable for the special mode load |
| cke | output | 1 | Clock enable, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dsf | output | 1 | Selects the special mode load |
| ba | output | 1 | Bank address |
| addr | output | ADDR_W | Address bus |
| dqm | output | DQM_W | Data masks |
| ready | output | 1 | Initialisation complete |
| cfg_err | output | 1 | Colour and mask loads both requested |

## Verification
The assertions check on every cycle that the masks stay high before `ready`, that the precharge carries the all-bank bit, and that the mode load clears its reserved and test bits. They also check that the special mode load never sets both enables, that no command arrives sooner than its predecessor's gap, and that `ready` is sticky with an idle bus. Only the bench scenarios can show the exact settling length and the order of commands under each configuration. The same holds for exact gap lengths, the passed-through mode bits, and the restart after a reset in the middle of the sequence.

// File: rtl/gram_init_pkg.sv
// Shared types for the graphics DRAM power-up sequencer.
// Assumes active-low command pins and a separate special-function select.
package gram_init_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_PRE,
        CMD_REF,
        CMD_MRS,
        CMD_SMRS
    } cmd_e;

    typedef enum logic [2:0] {
        STEP_PRE,
        STEP_REF,
        STEP_MRS,
        STEP_SMRS,
        STEP_DONE
    } step_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic dsf;
    } pins_t;

    // Map a command onto the control pin pattern.
    function automatic pins_t encode_cmd(cmd_e c);
        pins_t p;
        unique case (c)
            CMD_PRE:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, dsf: 1'b0};
            CMD_REF:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, dsf: 1'b0};
            CMD_MRS:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0, dsf: 1'b0};
            CMD_SMRS: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0, dsf: 1'b1};
            default:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, dsf: 1'b0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/gram_init_timer.sv
// Down-counter that times the settling wait and the gaps between commands.
// Assumes a load value of gap-1 so that a load of 0 yields a one-cycle gap.
module gram_init_timer #(
    parameter int CNT_W   = 16,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             idle
);

    logic [CNT_W-1:0] cnt;

    // Count down; reset starts the settling wait.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= CNT_W'(RST_VAL);
        else if (load)      cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign idle = (cnt == '0);

endmodule

// File: rtl/gram_init_step.sv
// Walks the initialisation steps and picks the command and gap for each.
// Assumes N_REFRESH >= 2 and every gap >= 1 cycle.
module gram_init_step
    import gram_init_pkg::*;
#(
    parameter int N_REFRESH = 2,
    parameter int T_RP      = 3,
    parameter int T_RC      = 9,
    parameter int T_MRD     = 2,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle,
    input  logic             mrs_first,
    input  logic             smrs_en,
    output cmd_e             cmd,
    output logic             load,
    output logic [CNT_W-1:0] gap,
    output logic             done
);

    localparam int RW = $clog2(N_REFRESH + 1);

    step_e          step_q, step_d;
    logic [RW-1:0]  ref_left_q, ref_left_d;
    logic           mode_done_q, mode_done_d;

    // Choose the command to issue and the step that follows it.
    always_comb begin
        step_d      = step_q;
        ref_left_d  = ref_left_q;
        mode_done_d = mode_done_q;
        cmd         = CMD_NOP;
        load        = 1'b0;
        gap         = '0;
        if (idle && step_q != STEP_DONE) begin
            load = 1'b1;
            unique case (step_q)
                STEP_PRE: begin
                    cmd    = CMD_PRE;
                    gap    = CNT_W'(T_RP - 1);
                    step_d = mrs_first ? STEP_MRS : STEP_REF;
                end
                STEP_REF: begin
                    cmd        = CMD_REF;
                    gap        = CNT_W'(T_RC - 1);
                    ref_left_d = ref_left_q - 1'b1;
                    if (ref_left_q > RW'(1)) step_d = STEP_REF;
                    else                     step_d = mode_done_q ? STEP_DONE : STEP_MRS;
                end
                STEP_MRS: begin
                    cmd         = CMD_MRS;
                    gap         = CNT_W'(T_MRD - 1);
                    mode_done_d = 1'b1;
                    if (smrs_en)        step_d = STEP_SMRS;
                    else if (mrs_first) step_d = STEP_REF;
                    else                step_d = STEP_DONE;
                end
                STEP_SMRS: begin
                    cmd    = CMD_SMRS;
                    gap    = CNT_W'(T_MRD - 1);
                    step_d = mrs_first ? STEP_REF : STEP_DONE;
                end
                default: begin
                    cmd  = CMD_NOP;
                    load = 1'b0;
                end
            endcase
        end
    end

    // Hold the current step, refreshes still owed and whether the mode is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q      <= STEP_PRE;
            ref_left_q  <= RW'(N_REFRESH);
            mode_done_q <= 1'b0;
        end else begin
            step_q      <= step_d;
            ref_left_q  <= ref_left_d;
            mode_done_q <= mode_done_d;
        end
    end

    assign done = (step_q == STEP_DONE) && idle;

endmodule

// File: rtl/gram_init_pins.sv
// Registers the command pins, address, masks and ready flag.
// Assumes fixed field positions: all-bank bit 10, reserved bit 10 and
// test bits 8:7 in the mode word, colour enable bit 6, mask enable bit 5.
module gram_init_pins
    import gram_init_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DQM_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [ADDR_W-1:0] mode_word,
    input  logic              load_color,
    input  logic              load_mask,
    input  logic              done,
    output pins_t             pins,
    output logic [ADDR_W-1:0] addr,
    output logic [DQM_W-1:0]  dqm,
    output logic              ready
);

    localparam int AP_BIT  = 10;
    localparam int RFU_BIT = 10;
    localparam int TM_HI   = 8;
    localparam int TM_LO   = 7;
    localparam int LC_BIT  = 6;
    localparam int LM_BIT  = 5;

    logic [ADDR_W-1:0] addr_d;

    // Build the address for the command being issued.
    always_comb begin
        addr_d = '0;
        unique case (cmd)
            CMD_PRE: addr_d[AP_BIT] = 1'b1;
            CMD_MRS: begin
                addr_d          = mode_word;
                addr_d[RFU_BIT] = 1'b0;
                addr_d[TM_HI]   = 1'b0;
                addr_d[TM_LO]   = 1'b0;
            end
            CMD_SMRS: begin
                addr_d[LC_BIT] = load_color & ~load_mask;
                addr_d[LM_BIT] = load_mask & ~load_color;
            end
            default: addr_d = '0;
        endcase
    end

    // Register every pin; reset forces an idle, masked bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins  <= encode_cmd(CMD_NOP);
            addr  <= '0;
            dqm   <= '1;
            ready <= 1'b0;
        end else begin
            pins  <= encode_cmd(cmd);
            addr  <= addr_d;
            dqm   <= done ? '0 : '1;
            ready <= done;
        end
    end

endmodule

// File: rtl/gram_init_seq.sv
// Top of the graphics DRAM power-up sequencer: settling wait, precharge,
// refreshes and mode loads with enforced gaps, then ready.
// Assumes STAB_US*CLK_MHZ >= 1, N_REFRESH >= 2 and all gaps >= 1.
module gram_init_seq
    import gram_init_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int STAB_US   = 200,
    parameter int N_REFRESH = 2,
    parameter int T_RP      = 3,
    parameter int T_RC      = 9,
    parameter int T_MRD     = 2,
    parameter int ADDR_W    = 11,
    parameter int DQM_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_mode_word,
    input  logic              cfg_mrs_first,
    input  logic              cfg_smrs_en,
    input  logic              cfg_load_color,
    input  logic              cfg_load_mask,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              dsf,
    output logic              ba,
    output logic [ADDR_W-1:0] addr,
    output logic [DQM_W-1:0]  dqm,
    output logic              ready,
    output logic              cfg_err
);

    localparam int STAB_CYC = STAB_US * CLK_MHZ;
    localparam int GAP_MAX  = (T_RC > T_RP) ? ((T_RC > T_MRD) ? T_RC : T_MRD)
                                            : ((T_RP > T_MRD) ? T_RP : T_MRD);
    localparam int SPAN     = (STAB_CYC > GAP_MAX) ? STAB_CYC : GAP_MAX;
    localparam int CNT_W    = $clog2(SPAN + 1);

    logic             idle;
    logic             load;
    logic [CNT_W-1:0] gap;
    logic             done;
    cmd_e             cmd;
    pins_t            pins;

    gram_init_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (STAB_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (gap),
        .idle     (idle)
    );

    gram_init_step #(
        .N_REFRESH (N_REFRESH),
        .T_RP      (T_RP),
        .T_RC      (T_RC),
        .T_MRD     (T_MRD),
        .CNT_W     (CNT_W)
    ) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle      (idle),
        .mrs_first (cfg_mrs_first),
        .smrs_en   (cfg_smrs_en),
        .cmd       (cmd),
        .load      (load),
        .gap       (gap),
        .done      (done)
    );

    gram_init_pins #(
        .ADDR_W (ADDR_W),
        .DQM_W  (DQM_W)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .mode_word  (cfg_mode_word),
        .load_color (cfg_load_color),
        .load_mask  (cfg_load_mask),
        .done       (done),
        .pins       (pins),
        .addr       (addr),
        .dqm        (dqm),
        .ready      (ready)
    );

    assign cke     = 1'b1;
    assign ba      = 1'b0;
    assign cs_n    = pins.cs_n;
    assign ras_n   = pins.ras_n;
    assign cas_n   = pins.cas_n;
    assign we_n    = pins.we_n;
    assign dsf     = pins.dsf;
    assign cfg_err = cfg_smrs_en & cfg_load_color & cfg_load_mask;

endmodule

// File: rtl/gram_init_chk.sv
// Property checker for the power-up sequencer, bound to its top module.
// Assumes the pin encodings and field positions of the sequencer.
module gram_init_chk #(
    parameter int ADDR_W = 11,
    parameter int DQM_W  = 4,
    parameter int T_RP   = 3,
    parameter int T_RC   = 9,
    parameter int T_MRD  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic              dsf,
    input logic [ADDR_W-1:0] addr,
    input logic [DQM_W-1:0]  dqm,
    input logic              ready
);

    logic [4:0]  bus;
    logic        is_nop, is_pre, is_ref, is_mrs, is_smrs, is_cmd;
    logic [15:0] since_q;
    logic [15:0] need_q;
    logic        seen_q;

    assign bus     = {cs_n, ras_n, cas_n, we_n, dsf};
    assign is_nop  = (bus == 5'b01110);
    assign is_pre  = (bus == 5'b00100);
    assign is_ref  = (bus == 5'b00010);
    assign is_mrs  = (bus == 5'b00000);
    assign is_smrs = (bus == 5'b00001);
    assign is_cmd  = is_pre | is_ref | is_mrs | is_smrs;

    // Track distance from the last command and the gap that command demands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
            need_q  <= '0;
            seen_q  <= 1'b0;
        end else if (is_cmd) begin
            since_q <= 16'd1;
            seen_q  <= 1'b1;
            need_q  <= is_pre ? 16'(T_RP) : (is_ref ? 16'(T_RC) : 16'(T_MRD));
        end else if (since_q != 16'hFFFF) begin
            since_q <= since_q + 1'b1;
        end
    end

    // R1
    dqm_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (dqm == '1));

    // R3
    pre_allbank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> addr[10]);

    // R6
    mode_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (addr[10] == 1'b0 && addr[8:7] == 2'b00));

    // R7
    smode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_smrs |-> !(addr[6] && addr[5]));

    // R8
    cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && seen_q) |-> (since_q >= need_q));

    // R9
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R9
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> is_nop);

endmodule

bind gram_init_seq gram_init_chk #(
    .ADDR_W (ADDR_W),
    .DQM_W  (DQM_W),
    .T_RP   (T_RP),
    .T_RC   (T_RC),
    .T_MRD  (T_MRD)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .dsf   (dsf),
    .addr  (addr),
    .dqm   (dqm),
    .ready (ready)
);

// File: tb/gram_init_seq_bench.sv
// Self-checking bench: a configuration table walked by one loop, then
// directed checks of the reset state and a restart mid-sequence.
module gram_init_seq_bench;

    localparam int CLK_MHZ = 100;
    localparam int STAB_US = 1;
    localparam int NREF    = 3;
    localparam int TRP     = 3;
    localparam int TRC     = 5;
    localparam int TMRD    = 2;
    localparam int AW      = 11;
    localparam int DW      = 4;
    localparam int STAB    = STAB_US * CLK_MHZ;

    localparam logic [4:0] P_NOP  = 5'b01110;
    localparam logic [4:0] P_PRE  = 5'b00100;
    localparam logic [4:0] P_REF  = 5'b00010;
    localparam logic [4:0] P_MRS  = 5'b00000;
    localparam logic [4:0] P_SMRS = 5'b00001;

    // {mrs_first, smrs_en, load_color, load_mask, mode_word[10:0]}
    localparam int NVEC = 5;
    localparam logic [14:0] VEC [NVEC] = '{
        {4'b0000, 11'h032},
        {4'b1000, 11'h7FF},
        {4'b0110, 11'h223},
        {4'b1101, 11'h021},
        {4'b0111, 11'h0A5}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_mode_word = '0;
    logic          cfg_mrs_first = 1'b0;
    logic          cfg_smrs_en = 1'b0;
    logic          cfg_load_color = 1'b0;
    logic          cfg_load_mask = 1'b0;
    logic          cke, cs_n, ras_n, cas_n, we_n, dsf, ba, ready, cfg_err;
    logic [AW-1:0] addr;
    logic [DW-1:0] dqm;

    int n_chk = 0;
    int n_bad = 0;

    int         exp_n;
    int         exp_t;
    int         exp_at   [16];
    logic [4:0] exp_pin  [16];
    logic [AW-1:0] exp_adr [16];

    always #5 clk = ~clk;

    gram_init_seq #(
        .CLK_MHZ   (CLK_MHZ),
        .STAB_US   (STAB_US),
        .N_REFRESH (NREF),
        .T_RP      (TRP),
        .T_RC      (TRC),
        .T_MRD     (TMRD),
        .ADDR_W    (AW),
        .DQM_W     (DW)
    ) u_gram_init_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_mode_word  (cfg_mode_word),
        .cfg_mrs_first  (cfg_mrs_first),
        .cfg_smrs_en    (cfg_smrs_en),
        .cfg_load_color (cfg_load_color),
        .cfg_load_mask  (cfg_load_mask),
        .cke            (cke),
        .cs_n           (cs_n),
        .ras_n          (ras_n),
        .cas_n          (cas_n),
        .we_n           (we_n),
        .dsf            (dsf),
        .ba             (ba),
        .addr           (addr),
        .dqm            (dqm),
        .ready          (ready),
        .cfg_err        (cfg_err)
    );

    task automatic push(input logic [4:0] p, input logic [AW-1:0] a, input int gap);
        exp_at[exp_n]  = exp_t;
        exp_pin[exp_n] = p;
        exp_adr[exp_n] = a;
        exp_n++;
        exp_t += gap;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Apply one configuration, build the expected schedule, compare each cycle.
    task automatic run_cfg(input logic [14:0] v, input int stop_k);
        logic          mf, se, lc, lm, err_e;
        logic [AW-1:0] mw, sa;
        int            last_k;
        {mf, se, lc, lm, mw} = v;
        cfg_mrs_first  = mf;
        cfg_smrs_en    = se;
        cfg_load_color = lc;
        cfg_load_mask  = lm;
        cfg_mode_word  = mw;
        err_e = se & lc & lm;
        // R7: colour on bit 6, mask on bit 5, neither if both requested
        sa = '0;
        sa[6] = lc & ~lm;
        sa[5] = lm & ~lc;
        exp_n = 0;
        exp_t = STAB;
        // R1 R3: precharge first, all-bank bit set
        push(P_PRE, 11'h400, TRP);
        if (mf) begin
            // R5
            push(P_MRS, mw & ~11'h580, TMRD);
            if (se) push(P_SMRS, sa, TMRD);
            for (int i = 0; i < NREF; i++) push(P_REF, '0, TRC);
        end else begin
            // R4
            for (int i = 0; i < NREF; i++) push(P_REF, '0, TRC);
            push(P_MRS, mw & ~11'h580, TMRD);
            if (se) push(P_SMRS, sa, TMRD);
        end
        last_k = (stop_k > 0) ? stop_k : exp_t + 4;
        do_reset();
        for (int k = 1; k <= last_k; k++) begin
            logic [4:0]    ep;
            logic [AW-1:0] ea;
            logic          er;
            logic [DW-1:0] ed;
            string         tag;
            @(posedge clk);
            @(negedge clk);
            ep  = P_NOP;
            ea  = '0;
            tag = (k < STAB) ? "R1" : "R8";
            for (int j = 0; j < exp_n; j++) begin
                if (exp_at[j] == k) begin
                    ep = exp_pin[j];
                    ea = exp_adr[j];
                    if (ep == P_PRE)       tag = "R2 R3";
                    else if (ep == P_MRS)  tag = "R2 R6";
                    else if (ep == P_SMRS) tag = "R2 R7";
                    else                   tag = mf ? "R2 R5" : "R2 R4";
                end
            end
            er = (k >= exp_t);
            ed = er ? '0 : '1;
            if (k == exp_t) tag = "R9";
            if (stop_k > 0) tag = {tag, " R10"};
            n_chk++;
            if ({cs_n, ras_n, cas_n, we_n, dsf} !== ep || addr !== ea || ba !== 1'b0 ||
                cke !== 1'b1 || dqm !== ed || ready !== er || cfg_err !== err_e) begin
                n_bad++;
                $display("FAIL %s cycle %0d: pins=%b addr=%h ba=%b cke=%b dqm=%h ready=%b err=%b expected pins=%b addr=%h ba=0 cke=1 dqm=%h ready=%b err=%b",
                         tag, k, {cs_n, ras_n, cas_n, we_n, dsf}, addr, ba, cke, dqm, ready, cfg_err,
                         ep, ea, ed, er, err_e);
            end
        end
    endtask

    initial begin
        // R1: reset state after edges in reset
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if ({cs_n, ras_n, cas_n, we_n, dsf} !== P_NOP || cke !== 1'b1 ||
            dqm !== '1 || ready !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: pins=%b cke=%b dqm=%h ready=%b expected pins=%b cke=1 dqm=f ready=0",
                     {cs_n, ras_n, cas_n, we_n, dsf}, cke, dqm, ready, P_NOP);
        end

        for (int v = 0; v < NVEC; v++) run_cfg(VEC[v], 0);

        // R10: interrupt during the refreshes, then require a full restart
        run_cfg(VEC[0], STAB + TRP + 2);
        run_cfg(VEC[0], 0);
        // R10: interrupt after ready, restart with the other ordering
        run_cfg(VEC[1], 0);
        run_cfg(VEC[3], 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule